// File: doc/BRIEF.md
# Pulse Voice Bank with Tremolo

This block is the tone generator of a small synthesizer. It holds a parameterizable number of voices. A host scheduler addresses each voice with a command that carries a tone period, counted in sample strobes, and an on/off flag. Each active voice produces a two-level pulse wave. Its high portion is set by an 8-bit duty control. A voice that is off contributes silence.

All voices share one triangle low-frequency oscillator that gives a tremolo. An 8-bit rate control sets its speed, and a rate of zero switches the effect off. Each voice level is scaled by the tremolo gain in a fixed-point multiply that keeps the high half of the product. One multiplier and one adder walk through the voices one at a time after every sample strobe. The saturated sum leaves the block with a single-cycle valid pulse.

Top module: `pulse_voice_bank`

## Requirements
- R1: A command with `cmd_valid` high, `cmd_note_on` high and voice index `cmd_voice` loads the period, sets the phase to 0 and makes the voice active from the next clock. A new note-on to a voice that is already active restarts its phase at 0.
- R2: A command with `cmd_note_on` low makes the addressed voice inactive, and an inactive voice adds 0 to the sum. With every voice inactive, `mix_out` is 0.
- R3: Every sample strobe advances an active voice's phase by one, modulo its period. After the advance, the voice's raw level is +`VOICE_PEAK` when phase < high length, and -`VOICE_PEAK` otherwise.
- R4: The high length is floor(period × duty / 256), raised to 1 when that value is 0.
- R5: A changed duty value reaches a voice only when its phase wraps to 0 or when it receives a note-on. Strobes in between keep the previous high length.
- R6: While the tremolo rate register is zero, the gain is 255.
- R7: While the rate register is nonzero, each strobe adds it to a 16-bit accumulator. Let t be the accumulator's top byte. The gain is 128 + t for t < 128, and 128 + (255 − t) for t ≥ 128.
- R8: The rate register reloads from `trem_ctrl` when the accumulator carries out, and also on any strobe while the register is zero. A reload of zero disables the tremolo.
- R9: Each voice's contribution is (raw level × gain) shifted arithmetically right by 8. The high bits are kept and the result rounds toward minus infinity.
- R10: The sum of all contributions saturates to the range −32768 … 32767 instead of wrapping.
- R11: `mix_valid` is high for exactly one cycle, at the (N+1)th rising edge after the edge that samples `sample_tick`, where N is `NUM_VOICES`. `mix_out` changes only together with that pulse.
- R12: After reset, every voice is inactive, the tremolo is disabled, `mix_out` is 0 and `mix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe that starts a new output sample |
| cmd_valid | input | 1 | Voice command strobe |
| cmd_voice | input | VIDX_W | Index of the addressed voice |
| cmd_note_on | input | 1 | 1 = start note, 0 = silence voice |
| cmd_period | input | PERIOD_W | Tone period in strobes (at least 2) |
| duty_ctrl | input | CTRL_W | Pulse duty control, in 1/256 of the period |
| trem_ctrl | input | CTRL_W | Tremolo rate; 0 disables |
| mix_out | output | SAMPLE_W | Signed summed sample |
| mix_valid | output | 1 | One-cycle pulse marking a new `mix_out` |

## Verification
The assertions take several things for granted about the inputs:
- strobes are at least N+2 cycles apart;
- no command arrives in the same cycle as a strobe;
- no command arrives while a sum is being accumulated;
- every note-on period is 2 or more.

The bench meets these conditions by construction. Commands are driven on falling edges only between strobes, and each strobe task waits for the valid pulse before it returns. All periods used are 2 or larger. A bench-side model of the phase, the latched high length and the tremolo accumulator gives the expected sample for every strobe.

// File: rtl/synth_pkg.sv
package synth_pkg;

   // Per-voice state seen by the mixer
   typedef struct packed {
      logic on;
      logic hi;
   } voice_tap_t;

   typedef enum logic [1:0] {
      MX_IDLE = 2'd0,
      MX_SUM  = 2'd1,
      MX_DONE = 2'd2
   } mix_state_t;

endpackage

// File: rtl/pulse_osc.sv
module pulse_osc #(
   parameter int unsigned PERIOD_W = 16,
   parameter int unsigned CTRL_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  load,
   input  logic                  note_on,
   input  logic [PERIOD_W-1:0]   period_in,
   input  logic [CTRL_W-1:0]     duty_in,
   output synth_pkg::voice_tap_t tap
);

   localparam int unsigned PROD_W = PERIOD_W + CTRL_W;

   logic                on_q;
   logic [PERIOD_W-1:0] per_q;
   logic [PERIOD_W-1:0] ph_q;
   logic [PERIOD_W-1:0] ht_q;

   function automatic logic [PERIOD_W-1:0] hi_len(input logic [PERIOD_W-1:0] per,
                                                   input logic [CTRL_W-1:0]   duty);
      logic [PROD_W-1:0]   prod;
      logic [PERIOD_W-1:0] h;
      prod = PROD_W'(per) * PROD_W'(duty);
      h    = prod[PROD_W-1:CTRL_W];
      if (h == '0)
         h = PERIOD_W'(1);
      else if (h >= per)
         h = per - PERIOD_W'(1);
      return h;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         per_q <= '0;
         ph_q  <= '0;
         ht_q  <= '0;
      end else if (load) begin
         if (note_on) begin
            on_q  <= 1'b1;
            per_q <= period_in;
            ph_q  <= '0;
            ht_q  <= hi_len(period_in, duty_in);
         end else begin
            on_q  <= 1'b0;
         end
      end else if (tick && on_q) begin
         if (ph_q == per_q - PERIOD_W'(1)) begin
            ph_q <= '0;
            ht_q <= hi_len(per_q, duty_in);
         end else begin
            ph_q <= ph_q + PERIOD_W'(1);
         end
      end
   end

   assign tap.on = on_q;
   assign tap.hi = on_q && (ph_q < ht_q);

endmodule

// File: rtl/trem_lfo.sv
module trem_lfo #(
   parameter int unsigned CTRL_W = 8,
   parameter int unsigned LFO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CTRL_W-1:0] rate_in,
   output logic [CTRL_W-1:0] gain
);

   logic [CTRL_W-1:0] rate_q;
   logic [LFO_W-1:0]  acc_q;
   logic [LFO_W:0]    sum;
   logic [CTRL_W-1:0] top;
   logic [CTRL_W-2:0] tri_v;

   assign sum = {1'b0, acc_q} + (LFO_W + 1)'(rate_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         acc_q  <= '0;
      end else if (tick) begin
         if (rate_q == '0) begin
            rate_q <= rate_in;
         end else begin
            acc_q <= sum[LFO_W-1:0];
            if (sum[LFO_W])
               rate_q <= rate_in;
         end
      end
   end

   assign top   = acc_q[LFO_W-1 -: CTRL_W];
   assign tri_v = top[CTRL_W-1] ? ~top[CTRL_W-2:0] : top[CTRL_W-2:0];
   assign gain  = (rate_q == '0) ? '1 : {1'b1, tri_v};

endmodule

// File: rtl/voice_mixer.sv
module voice_mixer #(
   parameter int unsigned NUM_VOICES = 4,
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned CTRL_W     = 8,
   parameter int unsigned VOICE_PEAK = 12000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick,
   input  synth_pkg::voice_tap_t       taps [NUM_VOICES],
   input  logic [CTRL_W-1:0]           gain,
   output logic signed [SAMPLE_W-1:0]  mix_out,
   output logic                        mix_valid
);

   localparam int unsigned IDX_W  = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1;
   localparam int unsigned ACC_W  = SAMPLE_W + IDX_W + 1;
   localparam int unsigned PROD_W = SAMPLE_W + CTRL_W + 1;
   localparam logic signed [SAMPLE_W-1:0] PEAK_S = SAMPLE_W'(VOICE_PEAK);
   localparam logic signed [ACC_W-1:0]    SAT_HI = ACC_W'((2 ** (SAMPLE_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0]    SAT_LO = -SAT_HI - ACC_W'(1);

   synth_pkg::mix_state_t         st_q;
   logic [IDX_W-1:0]              idx_q;
   logic signed [ACC_W-1:0]       acc_q;
   synth_pkg::voice_tap_t         sel;
   logic signed [SAMPLE_W-1:0]    raw;
   logic signed [PROD_W-1:0]      prod;
   logic signed [SAMPLE_W-1:0]    scaled;
   logic signed [SAMPLE_W-1:0]    sat_val;
   logic signed [SAMPLE_W-1:0]    out_q;
   logic                          vld_q;

   if (NUM_VOICES == 1) begin : g_single
      assign sel = taps[0];
   end else begin : g_mux
      assign sel = taps[idx_q];
   end

   assign raw    = !sel.on ? '0 : (sel.hi ? PEAK_S : -PEAK_S);
   assign prod   = PROD_W'(raw) * PROD_W'($signed({1'b0, gain}));
   assign scaled = prod[SAMPLE_W+CTRL_W-1:CTRL_W];

   always_comb begin
      if (acc_q > SAT_HI)
         sat_val = SAT_HI[SAMPLE_W-1:0];
      else if (acc_q < SAT_LO)
         sat_val = SAT_LO[SAMPLE_W-1:0];
      else
         sat_val = acc_q[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= synth_pkg::MX_IDLE;
         idx_q <= '0;
         acc_q <= '0;
         out_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (tick) begin
            st_q  <= synth_pkg::MX_SUM;
            idx_q <= '0;
            acc_q <= '0;
         end else begin
            case (st_q)
               synth_pkg::MX_SUM: begin
                  acc_q <= acc_q + ACC_W'(scaled);
                  if (idx_q == IDX_W'(NUM_VOICES - 1))
                     st_q <= synth_pkg::MX_DONE;
                  else
                     idx_q <= idx_q + IDX_W'(1);
               end
               synth_pkg::MX_DONE: begin
                  out_q <= sat_val;
                  vld_q <= 1'b1;
                  st_q  <= synth_pkg::MX_IDLE;
               end
               default: st_q <= synth_pkg::MX_IDLE;
            endcase
         end
      end
   end

   assign mix_out   = out_q;
   assign mix_valid = vld_q;

endmodule

// File: rtl/pulse_voice_bank.sv
module pulse_voice_bank #(
   parameter int unsigned NUM_VOICES = 4,
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned CTRL_W     = 8,
   parameter int unsigned LFO_W      = 16,
   parameter int unsigned VOICE_PEAK = 12000,
   localparam int unsigned VIDX_W    = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_tick,
   input  logic                       cmd_valid,
   input  logic [VIDX_W-1:0]          cmd_voice,
   input  logic                       cmd_note_on,
   input  logic [PERIOD_W-1:0]        cmd_period,
   input  logic [CTRL_W-1:0]          duty_ctrl,
   input  logic [CTRL_W-1:0]          trem_ctrl,
   output logic signed [SAMPLE_W-1:0] mix_out,
   output logic                       mix_valid
);

   if (NUM_VOICES < 1) begin : g_bad_voices
      $error("pulse_voice_bank: NUM_VOICES must be at least 1");
   end
   if (CTRL_W < 2 || LFO_W < CTRL_W) begin : g_bad_ctrl
      $error("pulse_voice_bank: need CTRL_W >= 2 and LFO_W >= CTRL_W");
   end
   if (VOICE_PEAK >= (2 ** (SAMPLE_W - 1))) begin : g_bad_peak
      $error("pulse_voice_bank: VOICE_PEAK exceeds the sample range");
   end

   synth_pkg::voice_tap_t taps [NUM_VOICES];
   logic [CTRL_W-1:0]     gain;

   for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
      pulse_osc #(
         .PERIOD_W (PERIOD_W),
         .CTRL_W   (CTRL_W)
      ) osc_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (sample_tick),
         .load      (cmd_valid && (cmd_voice == VIDX_W'(v))),
         .note_on   (cmd_note_on),
         .period_in (cmd_period),
         .duty_in   (duty_ctrl),
         .tap       (taps[v])
      );
   end

   trem_lfo #(
      .CTRL_W (CTRL_W),
      .LFO_W  (LFO_W)
   ) lfo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sample_tick),
      .rate_in (trem_ctrl),
      .gain    (gain)
   );

   voice_mixer #(
      .NUM_VOICES (NUM_VOICES),
      .SAMPLE_W   (SAMPLE_W),
      .CTRL_W     (CTRL_W),
      .VOICE_PEAK (VOICE_PEAK)
   ) mix_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .taps      (taps),
      .gain      (gain),
      .mix_out   (mix_out),
      .mix_valid (mix_valid)
   );

endmodule

// File: rtl/pulse_voice_bank_chk.sv
module pulse_voice_bank_chk #(
   parameter int unsigned NUM_VOICES = 4,
   parameter int unsigned VIDX_W     = 2,
   parameter int unsigned SAMPLE_W   = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       sample_tick,
   input logic                       cmd_valid,
   input logic [VIDX_W-1:0]          cmd_voice,
   input logic                       cmd_note_on,
   input synth_pkg::voice_tap_t      taps [NUM_VOICES],
   input logic signed [SAMPLE_W-1:0] mix_out,
   input logic                       mix_valid
);

   localparam int unsigned CNT_W = $clog2(NUM_VOICES + 3) + 1;

   logic [CNT_W-1:0] since_q;
   logic             seen_q;
   logic             any_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (sample_tick) begin
         since_q <= '0;
         seen_q  <= 1'b1;
      end else if (since_q != '1) begin
         since_q <= since_q + CNT_W'(1);
      end
   end

   always_comb begin
      any_on = 1'b0;
      for (int i = 0; i < NUM_VOICES; i++)
         any_on = any_on | taps[i].on;
   end

   for (genvar v = 0; v < NUM_VOICES; v++) begin : g_v
      a_r1_note_on_active: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_note_on && cmd_voice == VIDX_W'(v)) |=> taps[v].on);

      a_r2_note_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && !cmd_note_on && cmd_voice == VIDX_W'(v)) |=> !taps[v].on);

      a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
         (!sample_tick && !cmd_valid) |=> $stable(taps[v].hi));
   end

   a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
      mix_valid |-> (seen_q && since_q == CNT_W'(NUM_VOICES + 1)));

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mix_valid |=> !mix_valid);

   a_r11_out_held: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (mix_valid || $stable(mix_out)));

   a_r2_silent_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_valid && !any_on) |-> (mix_out == '0));

endmodule

bind pulse_voice_bank pulse_voice_bank_chk #(
   .NUM_VOICES (NUM_VOICES),
   .VIDX_W     (VIDX_W),
   .SAMPLE_W   (SAMPLE_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_tick (sample_tick),
   .cmd_valid   (cmd_valid),
   .cmd_voice   (cmd_voice),
   .cmd_note_on (cmd_note_on),
   .taps        (taps),
   .mix_out     (mix_out),
   .mix_valid   (mix_valid)
);

// File: tb/pulse_voice_bank_tb.sv
module pulse_voice_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV   = 4;
   localparam int PEAK = 12000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               sample_tick = 1'b0;
   logic               cmd_valid = 1'b0;
   logic [1:0]         cmd_voice = '0;
   logic               cmd_note_on = 1'b0;
   logic [15:0]        cmd_period = '0;
   logic [7:0]         duty_ctrl = '0;
   logic [7:0]         trem_ctrl = '0;
   logic signed [15:0] mix_out;
   logic               mix_valid;

   int checks = 0;
   int errors = 0;

   // bench-side model state
   int m_on [NV];
   int m_per [NV];
   int m_ph [NV];
   int m_ht [NV];
   int m_duty = 0;
   int m_trem = 0;
   int m_rate = 0;
   int m_acc  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pulse_voice_bank dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .cmd_valid   (cmd_valid),
      .cmd_voice   (cmd_voice),
      .cmd_note_on (cmd_note_on),
      .cmd_period  (cmd_period),
      .duty_ctrl   (duty_ctrl),
      .trem_ctrl   (trem_ctrl),
      .mix_out     (mix_out),
      .mix_valid   (mix_valid)
   );

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int calc_ht(input int per, input int duty);
      int h;
      h = (per * duty) >> 8;
      if (h == 0) h = 1;
      else if (h >= per) h = per - 1;
      return h;
   endfunction

   function automatic int model_gain();
      int t;
      if (m_rate == 0) return 255;
      t = m_acc >> 8;
      return (t < 128) ? 128 + t : 128 + (255 - t);
   endfunction

   function automatic int model_step();
      int s, g, sum, raw, p;
      if (m_rate == 0) begin
         m_rate = m_trem;
      end else begin
         s = m_acc + m_rate;
         m_acc = s & 16'hFFFF;
         if (s > 16'hFFFF) m_rate = m_trem;
      end
      g = model_gain();
      sum = 0;
      for (int v = 0; v < NV; v++) begin
         if (m_on[v] != 0) begin
            if (m_ph[v] == m_per[v] - 1) begin
               m_ph[v] = 0;
               m_ht[v] = calc_ht(m_per[v], m_duty);
            end else begin
               m_ph[v] = m_ph[v] + 1;
            end
            raw = (m_ph[v] < m_ht[v]) ? PEAK : -PEAK;
            p = raw * g;
            sum += (p >>> 8);
         end
      end
      if (sum > 32767) sum = 32767;
      if (sum < -32768) sum = -32768;
      return sum;
   endfunction

   task automatic send_cmd(input int v, input int per, input int on);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_voice = 2'(v);
      cmd_period = 16'(per);
      cmd_note_on = (on != 0);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (on != 0) begin
         m_on[v] = 1; m_per[v] = per; m_ph[v] = 0; m_ht[v] = calc_ht(per, m_duty);
      end else begin
         m_on[v] = 0;
      end
   endtask

   task automatic set_duty(input int d);
      @(negedge clk);
      duty_ctrl = 8'(d);
      m_duty = d;
   endtask

   task automatic set_trem(input int r);
      @(negedge clk);
      trem_ctrl = 8'(r);
      m_trem = r;
   endtask

   // one strobe, wait for the valid pulse, compare latency and sample
   task automatic tick_check(input string tag);
      int exp, cyc;
      exp = model_step();
      @(negedge clk);
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      cyc = 0;
      while (!mix_valid && cyc < 20) begin
         @(negedge clk);
         cyc++;
      end
      check_val({tag, " R11 latency"}, cyc, NV + 1);
      check_val(tag, int'(mix_out), exp);
   endtask

   task automatic all_off();
      for (int v = 0; v < NV; v++) send_cmd(v, 2, 0);
   endtask

   task automatic test_reset();
      check_val("R12 mix_out after reset", int'(mix_out), 0);
      check_val("R12 mix_valid after reset", int'(mix_valid), 0);
      tick_check("R12 R2 idle bank sums to zero");
      tick_check("R2 idle bank second strobe");
   endtask

   task automatic test_basic();
      set_duty(128);
      send_cmd(0, 4, 1);
      for (int i = 0; i < 8; i++) tick_check("R3 R6 R9 single voice pulse");
      all_off();
   endtask

   task automatic test_duty_clamp();
      set_duty(0);
      send_cmd(1, 10, 1);
      for (int i = 0; i < 10; i++) tick_check("R4 duty 0 clamped to 1");
      all_off();
      set_duty(255);
      send_cmd(2, 4, 1);
      for (int i = 0; i < 6; i++) tick_check("R4 duty 255");
      all_off();
   endtask

   task automatic test_duty_latch();
      set_duty(128);
      send_cmd(0, 8, 1);
      tick_check("R5 before duty change");
      tick_check("R5 before duty change");
      set_duty(32);
      for (int i = 0; i < 12; i++) tick_check("R5 duty applied at wrap");
      all_off();
   endtask

   task automatic test_retune();
      set_duty(128);
      send_cmd(0, 8, 1);
      for (int i = 0; i < 3; i++) tick_check("R1 first note");
      send_cmd(0, 6, 1);
      for (int i = 0; i < 7; i++) tick_check("R1 retune restarts phase");
      all_off();
   endtask

   task automatic test_sum_sat();
      set_duty(128);
      send_cmd(0, 2, 1);
      send_cmd(1, 2, 1);
      for (int i = 0; i < 3; i++) tick_check("R10 two voices in range");
      send_cmd(2, 2, 1);
      send_cmd(0, 2, 1);
      send_cmd(1, 2, 1);
      for (int i = 0; i < 4; i++) tick_check("R10 three voices saturate");
      send_cmd(1, 2, 0);
      send_cmd(2, 2, 0);
      for (int i = 0; i < 2; i++) tick_check("R2 note off removes voices");
      send_cmd(0, 2, 0);
      tick_check("R2 all off gives zero");
   endtask

   task automatic test_pulse_width();
      int hi_seen;
      tick_check("R11 pulse width strobe");
      @(negedge clk);
      hi_seen = int'(mix_valid);
      check_val("R11 valid is one cycle", hi_seen, 0);
   endtask

   task automatic test_trem();
      int guard;
      set_duty(64);
      send_cmd(0, 5, 1);
      set_trem(64);
      for (int i = 0; i < 60; i++) tick_check("R7 tremolo gain");
      set_trem(0);
      guard = 0;
      while (m_rate != 0 && guard < 1100) begin
         tick_check("R8 rate reload at wrap");
         guard++;
      end
      check_val("R8 tremolo disabled after wrap", m_rate, 0);
      for (int i = 0; i < 3; i++) tick_check("R6 disabled gain full");
      all_off();
   endtask

   initial begin
      for (int v = 0; v < NV; v++) begin
         m_on[v] = 0; m_per[v] = 2; m_ph[v] = 0; m_ht[v] = 1;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_basic();
      test_duty_clamp();
      test_duty_latch();
      test_retune();
      test_sum_sat();
      test_pulse_width();
      test_trem();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule